// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block acts as the slave side of a two-wire (I2C) bus in front of a byte-addressed memory array. It receives SCL and SDA through a synchronizer and detects START and STOP conditions. It then matches a 7-bit device address and collects a two-byte memory address. Write data goes into a page buffer. The buffer is copied into the array only after the master closes the write with STOP. A fixed busy period follows that STOP. During it the block refuses its own device address, so the master can poll for completion.

Reads can use the running address counter directly. They can also set the counter first with an address-only write header followed by a repeated START. A read continues byte after byte for as long as the master acknowledges. A write-protect input is sampled once per write transaction, and when it is high the transaction is rejected. The array size, the page size and the busy length are parameters. The default array is kept small so the design elaborates quickly, and it still takes the full two address bytes from the bus.

Top module: `sereep_slave`

## Requirements
- R1: The device address byte is acknowledged only if its upper seven bits equal binary 1010 followed by `strap_i[2:0]` and its bit 0 selects the direction (1 = read, 0 = write). Any other address byte is not acknowledged, and the block ignores the bus until the next START.
- R2: The block pulls SDA low (`sda_pull` = 1) during the ninth SCL clock of a matched device address byte, of both memory address bytes and of every accepted write data byte. `sda_pull` changes only while the synchronized SCL is low.
- R3: After configuration, every array byte reads as 0xFF.
- R4: Write data reaches the array only after the STOP that ends the write, and it reads back correctly once the busy period is over.
- R5: For `BUSY_CYCLES` system clocks after a STOP that ends a write carrying data, the device address is not acknowledged. After that period it is acknowledged again.
- R6: During a write only the low `PAGE_W` address bits advance. Data bytes beyond one page wrap around and overwrite earlier bytes of the same page.
- R7: `wp_i` is sampled on the SCL falling edge that ends the acknowledge of the second memory address byte. If it is high, the first data byte is not acknowledged, the array is unchanged, and no busy period follows.
- R8: A write header with two address bytes, followed by a repeated START and a read header, returns data from the given address.
- R9: A read with no address phase starts at the byte after the last byte accessed.
- R10: A read continues while the master acknowledges and ends on a NACK. The address counter crosses page boundaries during a read and wraps from the last array byte to address 0.
- R11: A STOP after the address bytes with no data byte loads the address counter, but starts no write and no busy period.
- R12: After reset, `sda_pull` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock level as seen on the wire |
| sda_i | input | 1 | Bus data level as seen on the wire |
| sda_pull | output | 1 | 1 = pull SDA low, 0 = release it |
| wp_i | input | 1 | Write protect, high rejects writes |
| strap_i | input | 3 | Board-strapped low device address bits |

## Verification
The bench writes 130 bytes from offset 126 of a page. A design that advanced the full counter would spill into the next page instead of overwriting offsets 126, 127 and 0. It polls the device straight after a commit STOP, where a design without the busy timer would acknowledge. It also polls right after a write-protected transaction and after an address-only STOP, where a design that started busy anyway would wrongly refuse. A sequential read runs from the last array byte into address 0 and from one page into the next, which catches a counter that wraps at the page. A current-address read after a random read exposes a counter that fails to advance past the last byte returned.

// File: rtl/sereep_pkg.sv
package sereep_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_AHI,
    PH_ALO,
    PH_WR,
    PH_RD
  } phase_t;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/sereep_line_front.sv
module sereep_line_front #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic scl_s,
  output logic sda_s,
  output logic wp_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam int NL = 3;
  localparam logic [NL-1:0] IDLE_LVL = 3'b011;

  logic [NL-1:0] stg [SYNC_N];
  logic [1:0]    prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SYNC_N; s++) stg[s] <= IDLE_LVL;
      prev <= 2'b11;
    end else begin
      stg[0] <= {wp_i, sda_i, scl_i};
      for (int s = 1; s < SYNC_N; s++) stg[s] <= stg[s-1];
      prev <= stg[SYNC_N-1][1:0];
    end
  end

  assign scl_s    = stg[SYNC_N-1][0];
  assign sda_s    = stg[SYNC_N-1][1];
  assign wp_s     = stg[SYNC_N-1][2];
  assign scl_rise = scl_s & ~prev[0];
  assign scl_fall = ~scl_s & prev[0];
  assign start_ev = scl_s & prev[0] & prev[1] & ~sda_s;
  assign stop_ev  = scl_s & prev[0] & ~prev[1] & sda_s;
endmodule

// File: rtl/sereep_store.sv
module sereep_store #(
  parameter int ADDR_W      = 10,
  parameter int PAGE_W      = 7,
  parameter int BUSY_CYCLES = 500000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [7:0]               rd_data,
  input  logic                     buf_we,
  input  logic [PAGE_W-1:0]        buf_idx,
  input  logic [7:0]               buf_din,
  input  logic                     clr_mask,
  input  logic                     commit_go,
  input  logic [ADDR_W-PAGE_W-1:0] commit_page,
  output logic                     busy
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int CW         = $clog2(BUSY_CYCLES + 1);

  logic [7:0]               mem  [DEPTH];
  logic [7:0]               pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]    mask;
  logic [CW-1:0]            cnt;
  logic [PAGE_W-1:0]        cp_idx;
  logic [ADDR_W-PAGE_W-1:0] cpage;
  logic                     copying;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[buf_idx] <= buf_din;
  end

  always_ff @(posedge clk) begin
    if (rst) mask <= '0;
    else if (clr_mask && !busy) mask <= '0;
    else if (buf_we) mask[buf_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      copying <= 1'b0;
      cp_idx  <= '0;
      cpage   <= '0;
    end else if (commit_go) begin
      cnt     <= CW'(BUSY_CYCLES);
      copying <= 1'b1;
      cp_idx  <= '0;
      cpage   <= commit_page;
    end else begin
      if (cnt != '0) cnt <= cnt - 1'b1;
      if (copying) begin
        cp_idx <= cp_idx + 1'b1;
        if (&cp_idx) copying <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (copying && mask[cp_idx]) mem[{cpage, cp_idx}] <= pbuf[cp_idx];
    rd_data <= mem[rd_addr];
  end

  assign busy = (cnt != '0);

  a_r4_copy_within_busy: assert property (@(posedge clk) disable iff (rst)
    copying |-> busy);
endmodule

// File: rtl/sereep_slave.sv
module sereep_slave
  import sereep_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int PAGE_W      = 7,
  parameter int BUSY_CYCLES = 500000,
  parameter int SYNC_N      = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull,
  input  logic       wp_i,
  input  logic [2:0] strap_i
);
  localparam int AHI_W = ADDR_W - 8;

  logic scl_s, sda_s, wp_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic busy;
  logic [7:0] rd_data;

  phase_t            ph;
  logic [3:0]        bit_cnt;
  logic [7:0]        shreg;
  logic [7:0]        tx;
  logic [AHI_W-1:0]  ahi;
  logic [ADDR_W-1:0] ptr;
  logic              rw, mack, wp_lat, have_data;
  logic              dev_hit, buf_we, commit_go;

  sereep_line_front #(.SYNC_N(SYNC_N)) u_front (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .wp_i(wp_i),
    .scl_s(scl_s), .sda_s(sda_s), .wp_s(wp_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  assign dev_hit   = (shreg[7:1] == {DEV_CODE, strap_i}) && !busy;
  assign buf_we    = !start_ev && !stop_ev && scl_fall && (ph == PH_WR)
                     && (bit_cnt == 4'd8) && !wp_lat;
  assign commit_go = stop_ev && have_data;

  sereep_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BUSY_CYCLES(BUSY_CYCLES)) u_store (
    .clk(clk), .rst(rst),
    .rd_addr(ptr), .rd_data(rd_data),
    .buf_we(buf_we), .buf_idx(ptr[PAGE_W-1:0]), .buf_din(shreg),
    .clr_mask(start_ev), .commit_go(commit_go),
    .commit_page(ptr[ADDR_W-1:PAGE_W]),
    .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      tx        <= '0;
      ahi       <= '0;
      ptr       <= '0;
      rw        <= 1'b0;
      mack      <= 1'b0;
      wp_lat    <= 1'b0;
      have_data <= 1'b0;
      sda_pull  <= 1'b0;
    end else if (start_ev) begin
      ph        <= PH_DEV;
      bit_cnt   <= '0;
      sda_pull  <= 1'b0;
      have_data <= 1'b0;
    end else if (stop_ev) begin
      ph        <= PH_IDLE;
      bit_cnt   <= '0;
      sda_pull  <= 1'b0;
      have_data <= 1'b0;
    end else if (ph != PH_IDLE) begin
      if (scl_rise) begin
        if (bit_cnt < 4'd8) shreg <= {shreg[6:0], sda_s};
        else mack <= ~sda_s;
        bit_cnt <= bit_cnt + 4'd1;
      end else if (scl_fall) begin
        if (bit_cnt == 4'd8) begin
          case (ph)
            PH_DEV: begin
              if (dev_hit) begin
                sda_pull <= 1'b1;
                rw       <= shreg[0];
              end else begin
                ph <= PH_IDLE;
              end
            end
            PH_AHI: begin
              sda_pull <= 1'b1;
              ahi      <= shreg[AHI_W-1:0];
            end
            PH_ALO: begin
              sda_pull <= 1'b1;
              ptr      <= {ahi, shreg};
            end
            PH_WR: begin
              if (wp_lat) begin
                ph <= PH_IDLE;
              end else begin
                sda_pull  <= 1'b1;
                have_data <= 1'b1;
                ptr       <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
              end
            end
            default: sda_pull <= 1'b0;
          endcase
        end else if (bit_cnt == 4'd9) begin
          bit_cnt  <= '0;
          sda_pull <= 1'b0;
          case (ph)
            PH_DEV: begin
              if (rw) begin
                ph       <= PH_RD;
                sda_pull <= ~rd_data[7];
                tx       <= {rd_data[6:0], 1'b1};
                ptr      <= ptr + 1'b1;
              end else begin
                ph <= PH_AHI;
              end
            end
            PH_AHI: ph <= PH_ALO;
            PH_ALO: begin
              ph     <= PH_WR;
              wp_lat <= wp_s;
            end
            PH_RD: begin
              if (mack) begin
                sda_pull <= ~rd_data[7];
                tx       <= {rd_data[6:0], 1'b1};
                ptr      <= ptr + 1'b1;
              end else begin
                ph <= PH_IDLE;
              end
            end
            default: ;
          endcase
        end else if (ph == PH_RD) begin
          sda_pull <= ~tx[7];
          tx       <= {tx[6:0], 1'b1};
        end
      end
    end
  end

  a_r2_pull_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_pull) && !$past(start_ev) && !$past(stop_ev)) |-> !scl_s);

  a_r5_busy_refuses_address: assert property (@(posedge clk) disable iff (rst)
    (scl_fall && ph == PH_DEV && bit_cnt == 4'd8 && busy && !start_ev && !stop_ev)
    |=> !sda_pull);

  a_r7_protect_nacks_data: assert property (@(posedge clk) disable iff (rst)
    (scl_fall && ph == PH_WR && bit_cnt == 4'd8 && wp_lat && !start_ev && !stop_ev)
    |=> !sda_pull);

  a_r4_busy_starts_at_stop: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_ev));

  a_r11_bare_stop_no_busy: assert property (@(posedge clk) disable iff (rst)
    (stop_ev && !have_data && !busy) |=> !busy);
endmodule

// File: tb/tb_sereep_slave.sv
module tb_sereep_slave;
  localparam int CLK_P = 10;
  localparam int Q     = 8;
  localparam int AW    = 10;
  localparam int PW    = 7;
  localparam int BUSY  = 400;
  localparam int DEPTH = 1 << AW;
  localparam int PGB   = 1 << PW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_pull;
  logic line;

  assign line = sda_m & ~sda_pull;
  always #(CLK_P/2) clk = ~clk;

  sereep_slave #(.ADDR_W(AW), .PAGE_W(PW), .BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(line), .sda_pull(sda_pull),
    .wp_i(wp), .strap_i(strap)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int exp_v[$];
  string exp_t[$];
  int obs_v[$];
  logic [7:0] model [DEPTH];
  int mptr = 0;

  task automatic wq(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_v(int v, string t);
    exp_v.push_back(v);
    exp_t.push_back(t);
  endtask

  task automatic check_now(int got, int want, string t);
    checks++;
    if (got != want) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", t, got, want);
    end
  endtask

  always @(negedge clk) begin
    if (obs_v.size() > 0) begin
      int o;
      int e;
      string t;
      o = obs_v.pop_front();
      checks++;
      if (exp_v.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: got %0h expected nothing queued", o);
      end else begin
        e = exp_v.pop_front();
        t = exp_t.pop_front();
        if (o != e) begin
          errors++;
          $display("FAIL %s: got %0h expected %0h", t, o, e);
        end
      end
    end
  end

  task automatic i2c_start();
    sda_m = 1'b1; wq(Q);
    scl = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(Q);
    scl = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q);
      scl = 1'b1; wq(2*Q);
      scl = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q);
    scl = 1'b1; wq(Q);
    obs_v.push_back(line ? 0 : 1);
    wq(Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(bit ack);
    logic [7:0] v;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      scl = 1'b1; wq(Q);
      v = {v[6:0], line};
      wq(Q);
      scl = 1'b0; wq(Q);
    end
    sda_m = ack ? 1'b0 : 1'b1; wq(Q);
    scl = 1'b1; wq(2*Q);
    scl = 1'b0; wq(Q);
    sda_m = 1'b1;
    obs_v.push_back(int'(v));
  endtask

  function automatic logic [7:0] dev_byte(logic [2:0] s, bit r);
    return {4'b1010, s, r};
  endfunction

  task automatic put_byte(logic [7:0] b, int exp_ack, string t);
    expect_v(exp_ack, t);
    send_byte(b);
  endtask

  task automatic set_addr(int a, string t);
    i2c_start();
    put_byte(dev_byte(strap, 1'b0), 1, t);
    put_byte(a[15:8], 1, t);
    put_byte(a[7:0], 1, t);
    mptr = a % DEPTH;
  endtask

  task automatic write_run(int a, int n, int base, string t);
    int pg;
    pg = a & ~(PGB - 1);
    set_addr(a, t);
    for (int k = 0; k < n; k++) begin
      put_byte(8'(base + k), 1, t);
      model[pg | ((a + k) & (PGB - 1))] = 8'(base + k);
    end
    mptr = pg | ((a + n) & (PGB - 1));
    i2c_stop();
    wq(BUSY + 40);
  endtask

  task automatic read_cur(int n, string t);
    i2c_start();
    put_byte(dev_byte(strap, 1'b1), 1, t);
    for (int k = 0; k < n; k++) begin
      expect_v(int'(model[mptr]), t);
      recv_byte(k != n - 1);
      mptr = (mptr + 1) % DEPTH;
    end
    i2c_stop();
  endtask

  task automatic read_at(int a, int n, string t);
    set_addr(a, t);
    read_cur(n, t);
  endtask

  task automatic poll(int exp_ack, string t);
    i2c_start();
    put_byte(dev_byte(strap, 1'b0), exp_ack, t);
    i2c_stop();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    wq(5);
    rst = 1'b0;
    wq(2);
    check_now(int'(sda_pull), 0, "R12 sda_pull after reset");
    check_now(int'(line), 1, "R12 bus released after reset");

    read_at(16'h0005, 2, "R3/R8 erased array");

    // R4 byte write, R5 busy poll then ready
    set_addr(16'h0012, "R2 write header");
    put_byte(8'hA5, 1, "R2 data ack");
    model[16'h012] = 8'hA5;
    i2c_stop();
    poll(0, "R5 refused while busy");
    wq(BUSY);
    poll(1, "R5 accepted after busy");
    read_at(16'h0012, 1, "R4 committed byte");

    // R6 page wrap
    write_run(16'h017E, 130, 8'h40, "R6 page write");
    read_at(16'h017E, 3, "R6/R10 wrap and page cross");
    read_at(16'h0100, 2, "R6 overwritten start");
    read_cur(1, "R9 current address");

    // R7 write protect
    wp = 1'b1;
    set_addr(16'h0012, "R7 header under protect");
    put_byte(8'h3C, 0, "R7 data refused");
    i2c_stop();
    wp = 1'b0;
    poll(1, "R7 no busy after rejection");
    read_at(16'h0012, 1, "R7 array unchanged");

    // R1 address mismatch
    i2c_start();
    put_byte(dev_byte(strap ^ 3'b010, 1'b0), 0, "R1 strap mismatch");
    i2c_stop();
    i2c_start();
    put_byte({4'b1011, strap, 1'b1}, 0, "R1 code mismatch");
    i2c_stop();

    // R10 end of array wrap
    write_run(16'h0000, 1, 8'h5A, "R4 write low byte");
    read_at(DEPTH - 1, 2, "R10 wrap to zero");
    read_cur(1, "R9 after wrap");

    // R11 address-only stop
    set_addr(16'h0101, "R11 address only");
    i2c_stop();
    read_cur(1, "R11 no busy, counter loaded");

    wq(20);
    if (exp_v.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: got %0d results missing expected 0", exp_v.size());
    end
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end
endmodule